// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one phase-locked loop without ever sending an unstable clock downstream. A start pulse arrives with the requested reference divider (NR), feedback multiplier (NF) and post divider (NO), and an enable for the loop-bandwidth setting. The block first checks that the request keeps the oscillator and the output inside their legal frequency windows and that NO is usable. It then moves the clock output onto the reference oscillator, holds the PLL in reset, writes the minus-one encoded divider fields and waits a settle time. After that it releases reset, waits for the lock input and moves the output back onto the PLL.

The divider fields, the output mode select and the PLL reset line are the registered outputs that drive the analog macro. A rate readback gives the frequency the selected mode produces, so the effect of a sequence can be seen without a frequency counter. A lock that never arrives ends the sequence with an error, and the output stays on the reference oscillator.

Top module: `pll_reprog_seq`

## Requirements
- R1: `pll_mode` encodes 2'b00 = reference oscillator (slow), 2'b01 = PLL output (normal), 2'b10 = 32768 Hz source (deep slow). An accepted start sets `pll_mode` to slow at its own clock edge, and `pll_mode` is slow in every cycle in which `pll_rst` is high.
- R2: `pll_rst` rises one cycle after an accepted start. The divider and bandwidth fields change only in a cycle in which `pll_rst` is already high.
- R3: The fields are loaded as `fld_nr` = NR-1, `fld_no` = NO-1 and `fld_nf` = NF-1.
- R4: With `req_bwadj` high, `fld_bw` is loaded with (NF/2)-1, using integer halving. With `req_bwadj` low, `fld_bw` keeps its previous value.
- R5: `pll_rst` stays high for SETTLE_CYC+1 cycles: one cycle before the fields load and SETTLE_CYC cycles after.
- R6: `pll_mode` turns normal only at the edge that samples `pll_lock` high in the lock-wait state. `done` is high in that same cycle, with `busy` low.
- R7: A start while `busy` is high has no effect. The fields loaded are those of the accepted request.
- R8: `busy` is high from the cycle after an accepted start until the sequence ends. `done` is a single-cycle pulse.
- R9: A request is rejected when any of these holds: NR, NF or NO is zero or too large for its field; NO is neither 1 nor even; REF_KHZ*NF/NR is outside 300..1416 MHz; the output REF_KHZ*NF/(NR*NO) is outside 30..1416 MHz. A rejection sets `err` in the next cycle and leaves `busy`, `pll_rst`, `pll_mode` and all fields unchanged.
- R10: `rate_hz` shows REF_KHZ*1000 in slow mode, 32768 in deep slow mode and (REF_KHZ*NF / (NR*NO))*1000 in normal mode. It updates one cycle after the mode or fields change.
- R11: If `pll_lock` stays low for LOCK_TO cycles after reset release, `err` is set, `busy` falls, `done` stays low and `pll_mode` remains slow.
- R12: After reset, `pll_mode` is slow. `pll_rst`, `busy`, `done`, `err` and all fields are zero, and `rate_hz` equals REF_KHZ*1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| req_nr | input | NR_W+1 | Requested reference divider value |
| req_nf | input | NF_W+1 | Requested feedback multiplier value |
| req_no | input | NO_W+1 | Requested post divider value |
| req_bwadj | input | 1 | Load the bandwidth field with this request |
| pll_lock | input | 1 | Lock indication from the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at successful completion |
| err | output | 1 | Last request was rejected or timed out |
| pll_mode | output | 2 | Output source select |
| pll_rst | output | 1 | PLL reset control |
| fld_nr | output | NR_W | Reference divider field, value minus one |
| fld_no | output | NO_W | Post divider field, value minus one |
| fld_nf | output | NF_W | Feedback multiplier field, value minus one |
| fld_bw | output | BW_W | Bandwidth field |
| rate_hz | output | 32 | Rate readback in Hz |

## Verification
The bench applies requests that sit exactly on the 300 MHz and 1416 MHz oscillator limits, where a design that used strict comparisons would reject legal settings. It also applies requests just past those limits, where a design with an off-by-one comparison would reprogram the PLL with an illegal setting. It applies an odd NO, a too-small output frequency and zero or oversized dividers. For each one it confirms that no output moves, since a design that started the bypass before validating would glitch the clock. Further cases start a new request in the middle of a sequence, clear the bandwidth enable and withhold lock. These catch a sequencer that re-latched its inputs, overwrote the bandwidth field, or returned the output to an unlocked PLL. The bench also counts the reset-high cycles, which exposes a settle counter that runs one cycle short or long.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_DEEP   = 2'b10
  } pll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_HOLD     = 3'd1,
    ST_LOAD     = 3'd2,
    ST_SETTLE   = 3'd3,
    ST_LOCKWAIT = 3'd4
  } seq_state_e;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int REF_KHZ     = 24000,
  parameter int VCO_MIN_KHZ = 300000,
  parameter int VCO_MAX_KHZ = 1416000,
  parameter int OUT_MIN_KHZ = 30000,
  parameter int OUT_MAX_KHZ = 1416000
) (
  input  logic [NR_W:0] nr,
  input  logic [NF_W:0] nf,
  input  logic [NO_W:0] no,
  output logic          ok
);
  localparam int CW = 48;

  logic [CW-1:0] nr_w, nf_w, no_w, nrno;
  logic [CW-1:0] vco_num, vco_lo, vco_hi, out_lo, out_hi;
  logic          rng_ok, par_ok, vco_ok, out_ok;

  always_comb begin
    nr_w    = CW'(nr);
    nf_w    = CW'(nf);
    no_w    = CW'(no);
    nrno    = nr_w * no_w;
    vco_num = CW'(REF_KHZ) * nf_w;
    vco_lo  = CW'(VCO_MIN_KHZ) * nr_w;
    vco_hi  = CW'(VCO_MAX_KHZ) * nr_w;
    out_lo  = CW'(OUT_MIN_KHZ) * nrno;
    out_hi  = CW'(OUT_MAX_KHZ) * nrno;

    rng_ok = (nr_w != '0) && (nr_w <= (CW'(1) << NR_W)) &&
             (nf_w != '0) && (nf_w <= (CW'(1) << NF_W)) &&
             (no_w != '0) && (no_w <= (CW'(1) << NO_W));
    par_ok = (no_w == CW'(1)) || !no[0];
    vco_ok = (vco_num >= vco_lo) && (vco_num <= vco_hi);
    out_ok = (vco_num >= out_lo) && (vco_num <= out_hi);
    ok     = rng_ok && par_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + CNT_W'(1);
  end

  assign last = (cnt == limit - CNT_W'(1));
endmodule

// File: rtl/pll_field_bank.sv
module pll_field_bank #(
  parameter int NR_W = 6,
  parameter int NF_W = 13,
  parameter int NO_W = 4,
  parameter int BW_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            load_bw,
  input  logic [NR_W-1:0] nr_m1,
  input  logic [NO_W-1:0] no_m1,
  input  logic [NF_W-1:0] nf_m1,
  input  logic [BW_W-1:0] bw_val,
  output logic [NR_W-1:0] fld_nr,
  output logic [NO_W-1:0] fld_no,
  output logic [NF_W-1:0] fld_nf,
  output logic [BW_W-1:0] fld_bw
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fld_nr <= '0;
      fld_no <= '0;
      fld_nf <= '0;
      fld_bw <= '0;
    end else if (load) begin
      fld_nr <= nr_m1;
      fld_no <= no_m1;
      fld_nf <= nf_m1;
      if (load_bw) fld_bw <= bw_val;
    end
  end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4,
  parameter int REF_KHZ = 24000,
  parameter int DEEP_HZ = 32768
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic [NR_W-1:0] nr_m1,
  input  logic [NF_W-1:0] nf_m1,
  input  logic [NO_W-1:0] no_m1,
  output logic [31:0]     rate_hz
);
  import pll_seq_pkg::*;
  localparam int          CW     = 48;
  localparam logic [31:0] REF_HZ = 32'(REF_KHZ * 1000);

  logic [CW-1:0] num, den, quo;
  logic [31:0]   norm_hz;

  always_comb begin
    num     = CW'(REF_KHZ) * (CW'(nf_m1) + CW'(1));
    den     = (CW'(nr_m1) + CW'(1)) * (CW'(no_m1) + CW'(1));
    quo     = num / den;
    norm_hz = 32'(quo * CW'(1000));
  end

  always_ff @(posedge clk) begin
    if (rst) rate_hz <= REF_HZ;
    else begin
      case (mode)
        MODE_NORMAL: rate_hz <= norm_hz;
        MODE_DEEP:   rate_hz <= 32'(DEEP_HZ);
        default:     rate_hz <= REF_HZ;
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int NR_W       = 6,
  parameter int NF_W       = 13,
  parameter int NO_W       = 4,
  parameter int BW_W       = 12,
  parameter int REF_KHZ    = 24000,
  parameter int SETTLE_CYC = 500,
  parameter int LOCK_TO    = 2000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NR_W:0]   req_nr,
  input  logic [NF_W:0]   req_nf,
  input  logic [NO_W:0]   req_no,
  input  logic            req_bwadj,
  input  logic            pll_lock,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [1:0]      pll_mode,
  output logic            pll_rst,
  output logic [NR_W-1:0] fld_nr,
  output logic [NO_W-1:0] fld_no,
  output logic [NF_W-1:0] fld_nf,
  output logic [BW_W-1:0] fld_bw,
  output logic [31:0]     rate_hz
);
  import pll_seq_pkg::*;

  localparam int TMAX  = (SETTLE_CYC > LOCK_TO) ? SETTLE_CYC : LOCK_TO;
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_e      state;
  pll_mode_e       mode_q;
  logic            req_ok;
  logic            tmr_clr, tmr_en, tmr_last;
  logic [CNT_W-1:0] tmr_limit;

  logic [NR_W-1:0] lat_nr;
  logic [NO_W-1:0] lat_no;
  logic [NF_W-1:0] lat_nf;
  logic [BW_W-1:0] lat_bw;
  logic            lat_bw_en;
  logic [NF_W:0]   half_m1;

  pll_req_check #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ)
  ) u_check (
    .nr(req_nr), .nf(req_nf), .no(req_no), .ok(req_ok)
  );

  always_comb begin
    tmr_en    = (state == ST_SETTLE) || (state == ST_LOCKWAIT);
    tmr_clr   = (state == ST_LOAD) || ((state == ST_SETTLE) && tmr_last);
    tmr_limit = (state == ST_LOCKWAIT) ? CNT_W'(LOCK_TO) : CNT_W'(SETTLE_CYC);
    half_m1   = (req_nf >> 1) - (NF_W+1)'(1);
  end

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en),
    .limit(tmr_limit), .last(tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= MODE_SLOW;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      pll_rst   <= 1'b0;
      lat_nr    <= '0;
      lat_no    <= '0;
      lat_nf    <= '0;
      lat_bw    <= '0;
      lat_bw_en <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (req_ok) begin
              lat_nr    <= NR_W'(req_nr - (NR_W+1)'(1));
              lat_no    <= NO_W'(req_no - (NO_W+1)'(1));
              lat_nf    <= NF_W'(req_nf - (NF_W+1)'(1));
              lat_bw    <= BW_W'(half_m1);
              lat_bw_en <= req_bwadj;
              mode_q    <= MODE_SLOW;
              busy      <= 1'b1;
              err       <= 1'b0;
              state     <= ST_HOLD;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          pll_rst <= 1'b1;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_last) begin
            pll_rst <= 1'b0;
            state   <= ST_LOCKWAIT;
          end
        end
        ST_LOCKWAIT: begin
          if (pll_lock) begin
            mode_q <= MODE_NORMAL;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else if (tmr_last) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pll_mode = mode_q;

  pll_field_bank #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
  ) u_fields (
    .clk(clk), .rst(rst),
    .load(state == ST_LOAD), .load_bw(lat_bw_en),
    .nr_m1(lat_nr), .no_m1(lat_no), .nf_m1(lat_nf), .bw_val(lat_bw),
    .fld_nr(fld_nr), .fld_no(fld_no), .fld_nf(fld_nf), .fld_bw(fld_bw)
  );

  pll_rate_calc #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ)
  ) u_rate (
    .clk(clk), .rst(rst), .mode(pll_mode),
    .nr_m1(fld_nr), .nf_m1(fld_nf), .no_m1(fld_no),
    .rate_hz(rate_hz)
  );
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
  parameter int NR_W = 6,
  parameter int NF_W = 13,
  parameter int NO_W = 4,
  parameter int BW_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [1:0]      pll_mode,
  input logic            pll_rst,
  input logic            pll_lock,
  input logic [NR_W-1:0] fld_nr,
  input logic [NO_W-1:0] fld_no,
  input logic [NF_W-1:0] fld_nf,
  input logic [BW_W-1:0] fld_bw
);
  import pll_seq_pkg::*;

  AST_RESET_IN_SLOW: assert property (@(posedge clk) disable iff (rst)
    pll_rst |-> (pll_mode == MODE_SLOW)); // R1

  AST_FIELDS_UNDER_RESET: assert property (@(posedge clk) disable iff (rst)
    !$stable({fld_nr, fld_no, fld_nf, fld_bw}) |-> pll_rst); // R2

  AST_NORMAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    ((pll_mode == MODE_NORMAL) && ($past(pll_mode) != MODE_NORMAL)) |-> $past(pll_lock)); // R6

  AST_DONE_IDLE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    done |-> ((pll_mode == MODE_NORMAL) && !busy)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (err && !$past(err) && !$past(busy)) |-> ($stable(pll_mode) && !pll_rst && !busy)); // R9

  AST_TIMEOUT_SLOW: assert property (@(posedge clk) disable iff (rst)
    (err && $past(busy)) |-> ((pll_mode == MODE_SLOW) && !done)); // R11
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
  .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .pll_mode(pll_mode), .pll_rst(pll_rst), .pll_lock(pll_lock),
  .fld_nr(fld_nr), .fld_no(fld_no), .fld_nf(fld_nf), .fld_bw(fld_bw)
);

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
  localparam int NR_W = 6, NF_W = 13, NO_W = 4, BW_W = 12;
  localparam int REF_KHZ = 24000, SETTLE = 500, LOCK_TO = 2000, LOCK_DLY = 20;
  localparam int MAXW = SETTLE + LOCK_TO + 50;

  typedef struct packed { int nr; int nf; int no; bit bw; bit ok; } vec_t;
  localparam vec_t VEC [11] = '{
    '{2,   25,  1, 1'b1, 1'b1},   // VCO exactly 300 MHz
    '{9,   400, 2, 1'b1, 1'b1},
    '{1,   60,  1, 1'b1, 1'b0},   // VCO 1440 MHz
    '{1,   59,  1, 1'b0, 1'b1},   // VCO exactly 1416 MHz, bw kept
    '{2,   24,  1, 1'b1, 1'b0},   // VCO 288 MHz
    '{1,   50,  3, 1'b1, 1'b0},   // odd NO
    '{1,   13, 16, 1'b1, 1'b0},   // output 19.5 MHz
    '{0,   25,  1, 1'b1, 1'b0},   // zero NR
    '{1,   50,  2, 1'b1, 1'b1},
    '{3,   100, 1, 1'b0, 1'b1},
    '{65,  100, 1, 1'b1, 1'b0}    // NR too wide
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NR_W:0] req_nr = '0;
  logic [NF_W:0] req_nf = '0;
  logic [NO_W:0] req_no = '0;
  logic req_bwadj = 1'b0;
  logic pll_lock = 1'b0;
  logic busy, done, err, pll_rst;
  logic [1:0] pll_mode;
  logic [NR_W-1:0] fld_nr;
  logic [NO_W-1:0] fld_no;
  logic [NF_W-1:0] fld_nf;
  logic [BW_W-1:0] fld_bw;
  logic [31:0] rate_hz;

  int checks = 0;
  int errors = 0;
  bit lock_en = 1'b1;
  int lcnt = 0;
  int m_nr = 0, m_nf = 0, m_no = 0, m_bw = 0, m_mode = 0;

  always #10 clk = ~clk;

  pll_reprog_seq #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W),
    .REF_KHZ(REF_KHZ), .SETTLE_CYC(SETTLE), .LOCK_TO(LOCK_TO)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .req_nr(req_nr), .req_nf(req_nf),
    .req_no(req_no), .req_bwadj(req_bwadj), .pll_lock(pll_lock),
    .busy(busy), .done(done), .err(err), .pll_mode(pll_mode), .pll_rst(pll_rst),
    .fld_nr(fld_nr), .fld_no(fld_no), .fld_nf(fld_nf), .fld_bw(fld_bw),
    .rate_hz(rate_hz)
  );

  // PLL stand-in: lock rises LOCK_DLY cycles after reset release
  always @(negedge clk) begin
    #3;
    if (pll_rst || !lock_en) begin
      lcnt = 0;
      pll_lock = 1'b0;
    end else if (lcnt < LOCK_DLY) begin
      lcnt = lcnt + 1;
      pll_lock = 1'b0;
    end else begin
      pll_lock = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_fields(input string req);
    chk(req, "fld_nr", fld_nr, m_nr - 1);
    chk(req, "fld_no", fld_no, m_no - 1);
    chk(req, "fld_nf", fld_nf, m_nf - 1);
    chk(req, "fld_bw", fld_bw, m_bw);
  endtask

  function automatic longint exp_rate();
    if (m_mode == 1) return (longint'(REF_KHZ) * m_nf) / (m_nr * m_no) * 1000;
    return longint'(REF_KHZ) * 1000;
  endfunction

  task automatic run_req(input int nr, input int nf, input int no, input bit bw,
                         input bit ok, input bit inject, input bit expect_lock);
    int rst_cyc, dones, bad_slow, bad_order, lock_bad, wait_cyc;
    bit seen_rst, fin_err;
    logic [NR_W+NO_W+NF_W+BW_W-1:0] prevf;
    rst_cyc = 0; dones = 0; bad_slow = 0; bad_order = 0; lock_bad = 0;
    wait_cyc = 0; seen_rst = 0; fin_err = 0;
    prevf = {fld_nr, fld_no, fld_nf, fld_bw};
    @(negedge clk);
    req_nr = (NR_W+1)'(nr); req_nf = (NF_W+1)'(nf); req_no = (NO_W+1)'(no);
    req_bwadj = bw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!ok) begin
      chk("R9", "err after reject", err, 1);
      chk("R9", "busy after reject", busy, 0);
      chk("R9", "pll_rst after reject", pll_rst, 0);
      chk("R9", "mode after reject", pll_mode, m_mode);
      check_fields("R9");
      return;
    end
    chk("R8", "busy after accept", busy, 1);
    chk("R1", "mode slow at accept", pll_mode, 0);
    chk("R2", "pll_rst not yet high", pll_rst, 0);
    for (int i = 0; i < MAXW; i++) begin
      @(negedge clk);
      if (inject && i == 3) begin
        req_nr = 7'd1; req_nf = 14'd59; req_no = 5'd1; req_bwadj = 1'b1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (pll_rst) begin rst_cyc++; seen_rst = 1; end
      if (pll_rst && pll_mode != 2'b00) bad_slow++;
      if ({fld_nr, fld_no, fld_nf, fld_bw} != prevf && !pll_rst) bad_order++;
      prevf = {fld_nr, fld_no, fld_nf, fld_bw};
      if (seen_rst && !pll_rst && busy) wait_cyc++;
      if (done) begin
        dones++;
        if (!pll_lock) lock_bad++;
        break;
      end
      if (err) begin fin_err = 1; break; end
    end
    start = 1'b0;
    chk("R1", "cycles with reset but not slow", bad_slow, 0);
    chk("R2", "field changes outside reset", bad_order, 0);
    chk("R5", "reset-high cycles", rst_cyc, SETTLE + 1);
    m_nr = nr; m_nf = nf; m_no = no;
    if (bw) m_bw = (nf / 2) - 1;
    if (expect_lock) begin
      chk("R6", "done seen", dones, 1);
      chk("R6", "lock high when normal", lock_bad, 0);
      chk("R6", "mode normal at done", pll_mode, 1);
      chk("R8", "busy low at done", busy, 0);
      m_mode = 1;
    end else begin
      chk("R11", "timeout err", fin_err, 1);
      chk("R11", "lock wait cycles", wait_cyc, LOCK_TO);
      chk("R11", "no done", dones, 0);
      chk("R11", "mode stays slow", pll_mode, 0);
      chk("R11", "busy low", busy, 0);
      m_mode = 0;
    end
    @(negedge clk);
    chk("R8", "done single cycle", done, 0);
    check_fields(bw ? "R4" : "R4 kept");
    check_fields("R3");
    chk("R10", "rate_hz", rate_hz, exp_rate());
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "mode", pll_mode, 0);
    chk("R12", "pll_rst", pll_rst, 0);
    chk("R12", "busy", busy, 0);
    chk("R12", "done", done, 0);
    chk("R12", "err", err, 0);
    chk("R12", "fld_nr", fld_nr, 0);
    chk("R12", "fld_nf", fld_nf, 0);
    chk("R12", "fld_bw", fld_bw, 0);
    chk("R12", "rate_hz", rate_hz, longint'(REF_KHZ) * 1000);
    m_nr = 1; m_nf = 1; m_no = 1; m_bw = 0; m_mode = 0;

    repeat (LOCK_DLY + 2) @(negedge clk);
    foreach (VEC[k]) begin
      run_req(VEC[k].nr, VEC[k].nf, VEC[k].no, VEC[k].bw, VEC[k].ok, 1'b0, 1'b1);
      repeat (LOCK_DLY + 2) @(negedge clk);
    end

    // R7: a second start during the sequence is ignored
    run_req(2, 50, 1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7", "fld_nf from first request", fld_nf, 49);
    repeat (LOCK_DLY + 2) @(negedge clk);

    // R11: lock never arrives
    lock_en = 1'b0;
    run_req(1, 25, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    lock_en = 1'b1;
    repeat (LOCK_DLY + 2) @(negedge clk);

    // recovery after timeout
    run_req(9, 500, 2, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9", "err cleared by accepted start", err, 0);

    finish_run();
  end
endmodule